// File: doc/BRIEF.md
# Chained-Block DMA Channel

This block is one DMA channel that runs a chain of block moves without software help between the blocks. Software places a table of three-word records in memory: a source address, a destination address and a byte count for each block. It then writes the table pointer, the number of blocks and the control bits, and starts the channel with a request. Before each block the channel reads the block's record from the table. It then moves the block one unit at a time. Each unit is a single read from the source followed by a single write to the destination, on a simple bus that waits on a ready signal.

A block ends when its count reaches zero. That does not stop the channel; it goes back to fetch the next record. The chain ends only when the block counter is already zero at the start of a fetch. At that point the channel pulses its active-low terminal-count output for one cycle, drops its enable and request bits, and raises a sticky interrupt flag. The channel has two modes. In burst mode one request runs the whole chain. In cycle-steal mode each request moves exactly one unit, with a record fetch first when the channel is at a block boundary.

Top module: `dma_chain_ch`

## Requirements
- R1: Register offsets on `cfg_addr` are as follows. 0 is the table pointer. 1 is the block counter. 2 is control: bit0 enable, bit1 request, bit2 unit size (1 = 16-bit, 0 = 8-bit), bit3 burst mode. 3 is status: bit0 is the interrupt flag. Writing control loads all four bits, and reads return the current values. After reset every register is zero, `tc_n` is 1 and `bus_req` is 0.
- R2: A record fetch makes three 16-bit little-endian reads, at pointer, pointer+2 and pointer+4. They load the source address, the destination address and the count, in that order. After the third read the pointer has advanced by 6 and the block counter has dropped by 1.
- R3: Each unit is one read at the source address followed by one write of that data to the destination address. Both addresses then advance by the unit size, 1 or 2 bytes.
- R4: After each unit the count drops by the unit size and saturates at zero. A block ends when the count reaches zero. A record whose count is zero moves no units.
- R5: When a block ends while blocks remain, the enable and request bits stay set and the next record is fetched.
- R6: If the block counter is zero when a fetch would start, the chain ends with no bus access. On that edge `tc_n` goes low for exactly one cycle, the enable and request bits clear, and the interrupt flag sets.
- R7: The interrupt flag, also driven on `irq`, stays set until software writes 1 to status bit0. Writing 0 leaves it set.
- R8: With burst mode off, `dreq_i` high sets the request bit, and each request moves exactly one unit. When a request finds no blocks left, it ends the chain. The request bit clears when the unit completes.
- R9: With burst mode on, a single request runs every block of the chain to its end with no further requests.
- R10: Clearing the enable bit mid-chain stops the channel at the next unit boundary, with no further bus access. Setting enable again resumes the same block where it stopped.
- R11: A bus access with `bus_ready` low keeps `bus_req`, `bus_addr` and `bus_we` unchanged until `bus_ready` is high at a clock edge. The access completes on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational) |
| dreq_i | input | 1 | Hardware transfer request |
| bus_req | output | 1 | Bus access valid |
| bus_we | output | 1 | Bus write (1) or read (0) |
| bus_wide | output | 1 | 16-bit access (1) or 8-bit access (0) |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |
| bus_ready | input | 1 | Access completes at this edge |
| tc_n | output | 1 | Chain-end pulse, active low |
| irq | output | 1 | Sticky chain-complete interrupt |

## Verification
A register write becomes visible on `cfg_rdata` one edge after the write strobe. A request set on one edge moves the channel out of idle on the next. The chain-end decision takes one idle-to-check cycle. The edge after it shows `tc_n` low, `irq` high and cleared control bits together, and `tc_n` returns high one edge later. The bus moves as fast as `bus_ready` allows, so the bench does not count cycles for a whole chain. It waits, with a cycle limit, for `irq`, or in cycle-steal mode for a fixed settle time after each request pulse. It samples only on falling edges, and counts the `tc_n` low cycles, bus writes and bus reads as they happen.

// File: rtl/dma_chain_pkg.sv
`timescale 1ns/1ps
package dma_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_RD,
    ST_WR
  } dc_state_t;

  localparam logic [1:0] RG_PTR  = 2'd0;
  localparam logic [1:0] RG_BLK  = 2'd1;
  localparam logic [1:0] RG_CTRL = 2'd2;
  localparam logic [1:0] RG_STAT = 2'd3;

  localparam int CB_EN    = 0;
  localparam int CB_REQ   = 1;
  localparam int CB_WIDE  = 2;
  localparam int CB_BURST = 3;

  // unit size in bytes for the selected access width
  function automatic logic [1:0] unit_step(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/dma_chain_regs.sv
`timescale 1ns/1ps
module dma_chain_regs
  import dma_chain_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int BCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  input  logic           dreq_i,
  input  logic           ev_block_load,
  input  logic           ev_chain_end,
  input  logic           ev_cs_done,
  output logic [AW-1:0]  ptr,
  output logic [BCW-1:0] blk,
  output logic           ctrl_en,
  output logic           ctrl_req,
  output logic           ctrl_wide,
  output logic           ctrl_burst,
  output logic           irq
);

  localparam int EB  = DW / 8;
  localparam int REC = 3 * EB;

  function automatic logic [AW-1:0] next_record(input logic [AW-1:0] p);
    return p + AW'(REC);
  endfunction

  logic wr_ptr, wr_blk, wr_ctrl, wr_stat;
  assign wr_ptr  = cfg_we && (cfg_addr == RG_PTR);
  assign wr_blk  = cfg_we && (cfg_addr == RG_BLK);
  assign wr_ctrl = cfg_we && (cfg_addr == RG_CTRL);
  assign wr_stat = cfg_we && (cfg_addr == RG_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      blk <= '0;
    end else if (ev_block_load) begin
      ptr <= next_record(ptr);
      blk <= blk - BCW'(1);
    end else begin
      if (wr_ptr) ptr <= cfg_wdata[AW-1:0];
      if (wr_blk) blk <= cfg_wdata[BCW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      ctrl_req   <= 1'b0;
      ctrl_wide  <= 1'b0;
      ctrl_burst <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_wide  <= cfg_wdata[CB_WIDE];
        ctrl_burst <= cfg_wdata[CB_BURST];
      end
      if (ev_chain_end) begin
        ctrl_en  <= 1'b0;
        ctrl_req <= 1'b0;
      end else if (wr_ctrl) begin
        ctrl_en  <= cfg_wdata[CB_EN];
        ctrl_req <= cfg_wdata[CB_REQ] | dreq_i;
      end else if (dreq_i) begin
        ctrl_req <= 1'b1;
      end else if (ev_cs_done) begin
        ctrl_req <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          irq <= 1'b0;
    else if (ev_chain_end)               irq <= 1'b1;
    else if (wr_stat && cfg_wdata[0])    irq <= 1'b0;
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RG_PTR:  cfg_rdata = DW'(ptr);
      RG_BLK:  cfg_rdata = DW'(blk);
      RG_CTRL: cfg_rdata = DW'({ctrl_burst, ctrl_wide, ctrl_req, ctrl_en});
      default: cfg_rdata = DW'(irq);
    endcase
  end

endmodule

// File: rtl/dma_chain_dp.sv
`timescale 1ns/1ps
module dma_chain_dp
  import dma_chain_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wide,
  input  logic          ld_sar,
  input  logic          ld_dar,
  input  logic          ld_tcr,
  input  logic [DW-1:0] ld_val,
  input  logic          cap_data,
  input  logic          unit_done,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] sar,
  output logic [AW-1:0] dar,
  output logic [DW-1:0] tcr,
  output logic [DW-1:0] tcr_after,
  output logic [DW-1:0] data_q
);

  function automatic logic [DW-1:0] count_after(input logic [DW-1:0] c,
                                                input logic [1:0] s);
    if (c > DW'(s)) return c - DW'(s);
    return '0;
  endfunction

  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a,
                                               input logic [1:0] s);
    return a + AW'(s);
  endfunction

  logic [1:0] step;
  assign step      = unit_step(ctrl_wide);
  assign tcr_after = count_after(tcr, step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sar <= '0;
      dar <= '0;
      tcr <= '0;
    end else if (unit_done) begin
      sar <= addr_after(sar, step);
      dar <= addr_after(dar, step);
      tcr <= tcr_after;
    end else begin
      if (ld_sar) sar <= ld_val[AW-1:0];
      if (ld_dar) dar <= ld_val[AW-1:0];
      if (ld_tcr) tcr <= ld_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        data_q <= '0;
    else if (cap_data) data_q <= ctrl_wide ? bus_rdata : DW'(bus_rdata[7:0]);
  end

endmodule

// File: rtl/dma_chain_seq.sv
`timescale 1ns/1ps
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_en,
  input  logic          ctrl_req,
  input  logic          ctrl_wide,
  input  logic          ctrl_burst,
  input  logic          blk_zero,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] sar,
  input  logic [AW-1:0] dar,
  input  logic [DW-1:0] tcr_after,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_wide,
  output logic [AW-1:0] bus_addr,
  output logic          ld_sar,
  output logic          ld_dar,
  output logic          ld_tcr,
  output logic          cap_data,
  output logic          ev_block_load,
  output logic          ev_unit_done,
  output logic          ev_chain_end,
  output logic          ev_cs_done,
  output logic          tc_n
);

  localparam int EB = DW / 8;

  function automatic logic [AW-1:0] entry_addr(input logic [AW-1:0] base,
                                               input logic [1:0] k);
    return base + AW'(k) * AW'(EB);
  endfunction

  dc_state_t  st, st_nx;
  logic [1:0] idx;
  logic       need_arr;
  logic       acc_done;

  assign acc_done = bus_req && bus_ready;

  always_comb begin
    bus_req  = 1'b0;
    bus_we   = 1'b0;
    bus_wide = ctrl_wide;
    bus_addr = '0;
    case (st)
      ST_FETCH: begin
        bus_req  = 1'b1;
        bus_wide = 1'b1;
        bus_addr = entry_addr(ptr, idx);
      end
      ST_RD: begin
        bus_req  = 1'b1;
        bus_addr = sar;
      end
      ST_WR: begin
        bus_req  = 1'b1;
        bus_we   = 1'b1;
        bus_addr = dar;
      end
      default: ;
    endcase
  end

  assign ld_sar        = (st == ST_FETCH) && acc_done && (idx == 2'd0);
  assign ld_dar        = (st == ST_FETCH) && acc_done && (idx == 2'd1);
  assign ld_tcr        = (st == ST_FETCH) && acc_done && (idx == 2'd2);
  assign ev_block_load = ld_tcr;
  assign cap_data      = (st == ST_RD) && acc_done;
  assign ev_unit_done  = (st == ST_WR) && acc_done;
  assign ev_cs_done    = ev_unit_done && !ctrl_burst;
  assign ev_chain_end  = (st == ST_CHECK) && ctrl_en && need_arr && blk_zero;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (ctrl_en && ctrl_req) st_nx = ST_CHECK;
      ST_CHECK: begin
        if (!ctrl_en)      st_nx = ST_IDLE;
        else if (need_arr) st_nx = blk_zero ? ST_IDLE : ST_FETCH;
        else               st_nx = ST_RD;
      end
      ST_FETCH: if (ld_tcr) st_nx = (bus_rdata == '0) ? ST_CHECK : ST_RD;
      ST_RD:    if (cap_data) st_nx = ST_WR;
      ST_WR: begin
        if (ev_unit_done) begin
          if (!ctrl_en || !ctrl_burst) st_nx = ST_IDLE;
          else if (tcr_after == '0)    st_nx = ST_CHECK;
          else                         st_nx = ST_RD;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= 2'd0;
      need_arr <= 1'b1;
      tc_n     <= 1'b1;
    end else begin
      st   <= st_nx;
      tc_n <= !ev_chain_end;
      if (st == ST_FETCH && acc_done) idx <= ld_tcr ? 2'd0 : idx + 2'd1;
      if (ld_tcr)            need_arr <= (bus_rdata == '0);
      else if (ev_unit_done) need_arr <= (tcr_after == '0);
    end
  end

endmodule

// File: rtl/dma_chain_ch.sv
`timescale 1ns/1ps
module dma_chain_ch
  import dma_chain_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int BCW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          dreq_i,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_wide,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          tc_n,
  output logic          irq
);

  logic [AW-1:0]  ptr, sar, dar;
  logic [BCW-1:0] blk;
  logic [DW-1:0]  tcr, tcr_after;
  logic ctrl_en, ctrl_req, ctrl_wide, ctrl_burst;
  logic ld_sar, ld_dar, ld_tcr, cap_data;
  logic ev_block_load, ev_unit_done, ev_chain_end, ev_cs_done;

  dma_chain_regs #(.AW(AW), .DW(DW), .BCW(BCW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dreq_i(dreq_i),
    .ev_block_load(ev_block_load), .ev_chain_end(ev_chain_end),
    .ev_cs_done(ev_cs_done),
    .ptr(ptr), .blk(blk),
    .ctrl_en(ctrl_en), .ctrl_req(ctrl_req),
    .ctrl_wide(ctrl_wide), .ctrl_burst(ctrl_burst), .irq(irq)
  );

  dma_chain_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl_wide(ctrl_wide),
    .ld_sar(ld_sar), .ld_dar(ld_dar), .ld_tcr(ld_tcr), .ld_val(bus_rdata),
    .cap_data(cap_data), .unit_done(ev_unit_done), .bus_rdata(bus_rdata),
    .sar(sar), .dar(dar), .tcr(tcr), .tcr_after(tcr_after), .data_q(bus_wdata)
  );

  dma_chain_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ctrl_en(ctrl_en), .ctrl_req(ctrl_req), .ctrl_wide(ctrl_wide),
    .ctrl_burst(ctrl_burst), .blk_zero(blk == '0),
    .ptr(ptr), .sar(sar), .dar(dar), .tcr_after(tcr_after),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide), .bus_addr(bus_addr),
    .ld_sar(ld_sar), .ld_dar(ld_dar), .ld_tcr(ld_tcr), .cap_data(cap_data),
    .ev_block_load(ev_block_load), .ev_unit_done(ev_unit_done),
    .ev_chain_end(ev_chain_end), .ev_cs_done(ev_cs_done), .tc_n(tc_n)
  );

endmodule

// File: rtl/dma_chain_chk.sv
`timescale 1ns/1ps
module dma_chain_chk #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int BCW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_we,
  input logic           bus_ready,
  input logic [AW-1:0]  bus_addr,
  input logic           tc_n,
  input logic           irq,
  input logic           ctrl_en,
  input logic           ctrl_req,
  input logic [BCW-1:0] blk,
  input logic [DW-1:0]  tcr,
  input logic           ev_block_load,
  input logic           ev_unit_done,
  input logic           ev_chain_end
);

  a_r11_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  a_r6_tc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_n |=> tc_n);

  a_r6_end_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chain_end |=> !tc_n && irq && !ctrl_en && !ctrl_req);

  a_r6_no_bus_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chain_end |-> !bus_req);

  a_r2_block_dec: assert property (@(posedge clk) disable iff (!rst_n)
    ev_block_load |=> blk == BCW'($past(blk) - 1'b1));

  a_r4_count_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unit_done |=> tcr < $past(tcr));

  a_r3_unit_ends_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unit_done |-> bus_we);

  a_r10_stop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unit_done && !ctrl_en |=> !bus_req);

endmodule

bind dma_chain_ch dma_chain_chk #(.AW(AW), .DW(DW), .BCW(BCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_ready(bus_ready), .bus_addr(bus_addr), .tc_n(tc_n), .irq(irq),
  .ctrl_en(ctrl_en), .ctrl_req(ctrl_req), .blk(blk), .tcr(tcr),
  .ev_block_load(ev_block_load), .ev_unit_done(ev_unit_done),
  .ev_chain_end(ev_chain_end)
);

// File: tb/dma_chain_ch_test.sv
`timescale 1ns/1ps
module dma_chain_ch_test;

  localparam int AW = 16, DW = 16, BCW = 8;

  typedef struct packed {
    logic       wide;
    logic       burst;
    logic [1:0] nblk;
    logic [7:0] c0;
    logic [7:0] c1;
    logic       slow;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{1'b0, 1'b1, 2'd1, 8'd5, 8'd0, 1'b0},
    '{1'b1, 1'b1, 2'd2, 8'd6, 8'd3, 1'b1},
    '{1'b0, 1'b1, 2'd2, 8'd0, 8'd4, 1'b0},
    '{1'b1, 1'b0, 2'd2, 8'd4, 8'd2, 1'b0},
    '{1'b0, 1'b0, 2'd1, 8'd3, 8'd0, 1'b1},
    '{1'b1, 1'b1, 2'd2, 8'd1, 8'd8, 1'b1}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = 2'd0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic          dreq_i = 1'b0;
  logic          bus_req, bus_we, bus_wide, bus_ready;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          tc_n, irq;
  logic          slow = 1'b0;
  logic [7:0]    mem [0:255];
  int unsigned   cyc = 0;
  int nwr = 0, nrd = 0, ntc = 0, nerr = 0, nchk = 0;
  int rdlog [0:7];

  dma_chain_ch #(.AW(AW), .DW(DW), .BCW(BCW)) uut (.*);

  assign bus_ready = slow ? cyc[0] : 1'b1;
  assign bus_rdata = bus_wide ? {mem[bus_addr[7:0] + 8'd1], mem[bus_addr[7:0]]}
                              : {8'h00, mem[bus_addr[7:0]]};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && bus_req && bus_ready) begin
      if (bus_we) begin
        mem[bus_addr[7:0]] = bus_wdata[7:0];
        if (bus_wide) mem[bus_addr[7:0] + 8'd1] = bus_wdata[15:8];
        nwr++;
      end else begin
        if (nrd < 8) rdlog[nrd] = int'(bus_addr);
        nrd++;
      end
    end
  end

  always @(negedge clk) if (rst_n && !tc_n) ntc++;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = DW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] a, output int v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = int'(cfg_rdata);
  endtask

  task automatic put16(input int a, input int v);
    mem[a] = v[7:0];
    mem[a + 1] = v[15:8];
  endtask

  task automatic mem_setup(input int c0, input int c1);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 8'h40; i < 8'h80; i++) mem[i] = 8'(i) ^ 8'h5A;
    put16(8'h10, 8'h40); put16(8'h12, 8'h80); put16(8'h14, c0);
    put16(8'h16, 8'h60); put16(8'h18, 8'hA0); put16(8'h1A, c1);
  endtask

  task automatic wait_irq(input int limit);
    for (int i = 0; i < limit && !irq; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_copy(input string tag, input int src, input int dst, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (mem[dst + i] != mem[src + i]) bad++;
    chk(tag, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R9 watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    vec_t t;
    int step, u0, u1, b0, b1, v, pulses, n1;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R1 reset tc_n", int'(tc_n), 1);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset bus_req", int'(bus_req), 0);
    cfg_rd(2'd2, v); chk("R1 reset ctrl", v, 0);
    cfg_rd(2'd0, v); chk("R1 reset ptr", v, 0);

    // chain with zero blocks ends at once
    ntc = 0; nrd = 0; nwr = 0;
    cfg_wr(2'd2, 4'b1011);
    repeat (10) @(negedge clk);
    chk("R6 tc_n low cycles", ntc, 1);
    chk("R6 no bus access", nrd + nwr, 0);
    chk("R6 irq set", int'(irq), 1);
    cfg_rd(2'd2, v); chk("R6 en/req cleared", v & 3, 0);

    // sticky interrupt flag
    repeat (5) @(negedge clk);
    chk("R7 irq holds", int'(irq), 1);
    cfg_wr(2'd3, 0);
    chk("R7 write 0 keeps irq", int'(irq), 1);
    cfg_wr(2'd3, 1);
    chk("R7 write 1 clears irq", int'(irq), 0);

    // vector table
    for (int k = 0; k < 6; k++) begin
      t = VECS[k];
      mem_setup(int'(t.c0), int'(t.c1));
      step = t.wide ? 2 : 1;
      u0 = (int'(t.c0) + step - 1) / step;
      u1 = (t.nblk > 1) ? (int'(t.c1) + step - 1) / step : 0;
      b0 = u0 * step; b1 = u1 * step;
      slow = t.slow;
      cfg_wr(2'd0, 8'h10);
      cfg_wr(2'd1, int'(t.nblk));
      cfg_wr(2'd3, 1);
      nwr = 0; nrd = 0; ntc = 0;
      cfg_wr(2'd2, {28'd0, t.burst, t.wide, t.burst, 1'b1});
      if (t.burst) begin
        wait_irq(600);
      end else begin
        pulses = 0;
        while (!irq && pulses < 40) begin
          @(negedge clk) dreq_i = 1'b1;
          @(negedge clk) dreq_i = 1'b0;
          pulses++;
          repeat (30) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk($sformatf("R8 vec%0d requests used", k), pulses, u0 + u1 + 1);
      end
      chk($sformatf("R6 vec%0d irq", k), int'(irq), 1);
      chk($sformatf("R6 vec%0d tc pulse", k), ntc, 1);
      cfg_rd(2'd2, v); chk($sformatf("R6 vec%0d en/req", k), v & 3, 0);
      chk($sformatf("R5 R9 vec%0d units written", k), nwr, u0 + u1);
      chk_copy($sformatf("R3 R11 vec%0d block0 data", k), 8'h40, 8'h80, b0);
      chk($sformatf("R4 vec%0d block0 stop", k), int'(mem[8'h80 + b0]), 0);
      if (t.nblk > 1) begin
        chk_copy($sformatf("R3 vec%0d block1 data", k), 8'h60, 8'hA0, b1);
        chk($sformatf("R4 vec%0d block1 stop", k), int'(mem[8'hA0 + b1]), 0);
      end
      cfg_rd(2'd0, v); chk($sformatf("R2 vec%0d ptr advance", k), v, 8'h10 + 6 * int'(t.nblk));
      cfg_rd(2'd1, v); chk($sformatf("R2 vec%0d block count", k), v, 0);
      if (k == 0) begin
        chk("R2 first read at ptr", rdlog[0], 8'h10);
        chk("R2 second read at ptr+2", rdlog[1], 8'h12);
        chk("R2 third read at ptr+4", rdlog[2], 8'h14);
        chk("R3 unit read at source", rdlog[3], 8'h40);
      end
    end

    // disable mid-chain, then resume
    mem_setup(20, 0);
    slow = 1'b1;
    cfg_wr(2'd0, 8'h10);
    cfg_wr(2'd1, 1);
    cfg_wr(2'd3, 1);
    nwr = 0; nrd = 0; ntc = 0;
    cfg_wr(2'd2, 4'b1011);
    for (int i = 0; i < 200 && nwr < 3; i++) @(negedge clk);
    cfg_wr(2'd2, 4'b1010);
    repeat (20) @(negedge clk);
    n1 = nwr;
    chk("R10 stop near boundary", int'(n1 >= 3 && n1 <= 5), 1);
    repeat (30) @(negedge clk);
    chk("R10 no more writes", nwr, n1);
    chk("R10 bus idle", int'(bus_req), 0);
    chk("R10 no irq while stopped", int'(irq), 0);
    cfg_wr(2'd2, 4'b1011);
    wait_irq(600);
    chk("R10 resume completes", nwr, 20);
    chk_copy("R10 resumed data", 8'h40, 8'h80, 20);
    chk("R10 one tc pulse", ntc, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule